// File: doc/BRIEF.md
# Shared Palette and Tile Lookup Memory

This block holds one 2048-entry colour memory that several display layers share. Each entry is one colour value of `DATA_W` bits. A layer uses the memory through a base offset and a mode. In the 16-colour mode a 4-bit pixel index picks one of 16 consecutive entries. In the 256-colour mode an 8-bit index picks one of 256 entries. In tile mode the 8x8 pixel position picks one of 64 entries, which hold the pixels of one tile. Layers that give the same base offset share one palette. The whole memory can therefore hold eight complete 256-entry palettes, or any mix of small palettes and tiles.

Software reaches the memory through a register bus that uses byte addresses inside a 16K window. The memory takes the upper half of that window, from 0x2000 to 0x3FFF, with one entry in each 32-bit word. Software writes are accepted only while the display is switched off or while it is in vertical blanking. A write that arrives while the display is scanning is dropped, and a sticky error flag records it. Pixel lookups return their colour one clock after the request, together with a matching valid flag.

Top module: `lut_share_ram`

## Requirements
- R1: A bus write to byte address 0x2000 + 4*i (bit 13 set, entry index in bits 12:2) stores the low `DATA_W` bits of the write data in entry i. A bus read of that address returns the entry on `busRdata` one cycle after the request, with bits 31:`DATA_W` at zero.
- R2: Bus addresses with bit 13 clear are outside the memory. A write there changes no entry and does not set the error flag. A read there returns zero.
- R3: A bus write inside the memory is accepted when `dispEnable` is 0 or when `vBlank` is 1.
- R4: A bus write inside the memory while `dispEnable` is 1 and `vBlank` is 0 is dropped and leaves the entry unchanged. It also sets `wrErr`, which stays at 1 until reset.
- R5: Mode code 0 (16 colours) looks up the entry at `layerBase` + `pixIndex[3:0]`. Index bits 7:4 are ignored.
- R6: Mode codes 1 and 3 (256 colours) look up the entry at `layerBase` + `pixIndex`.
- R7: Mode code 2 (tile) looks up the entry at `layerBase` + 8*`tileY` + `tileX`. `pixIndex` is ignored.
- R8: The lookup entry address wraps modulo 2048.
- R9: `lutValid` equals `pixValid` delayed by one cycle, and `lutData` carries the colour of the request made in the previous cycle.
- R10: After reset, `busRdata`, `lutValid` and `wrErr` are zero.
- R11: A lookup made in the same cycle as an accepted write to the same entry returns the contents from before the write. The next lookup returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 14 | Byte address within the 16K window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one cycle after a read |
| dispEnable | input | 1 | Display controller is running |
| vBlank | input | 1 | Display is in vertical blanking |
| pixValid | input | 1 | Pixel lookup request |
| pixIndex | input | 8 | Pixel colour index |
| layerBase | input | 11 | Layer base offset into the memory |
| layerMode | input | 2 | 0 = 16-colour, 1/3 = 256-colour, 2 = tile |
| tileX | input | 3 | Pixel column within the tile |
| tileY | input | 3 | Pixel row within the tile |
| lutValid | output | 1 | Lookup result valid |
| lutData | output | 24 | Looked-up colour |
| wrErr | output | 1 | Sticky flag for a dropped write |

## Verification
Two situations are the hardest to reach from the ports. The first is a pixel lookup and an accepted bus write that hit the same entry in the same clock. The second is a write attempt during active scan, which must leave the entry it targets unchanged. The bench reaches the first by driving both ports in one cycle at an entry whose old and new values differ, and then checking the lookup result before and after the write. It reaches the second by raising `dispEnable` with `vBlank` low, writing, and then reading the targeted entry back over the bus and through a lookup. All of this runs on top of full sweeps of the memory contents and of every index, every tile position and bases that wrap past the top of the memory.

// File: rtl/lutshr_pkg.sv
package lutshr_pkg;

  typedef enum logic [1:0] {
    MODE_PAL16  = 2'd0,
    MODE_PAL256 = 2'd1,
    MODE_TILE   = 2'd2,
    MODE_PAL256B = 2'd3
  } lut_mode_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic wrEn;   // commit bus write to memory
    logic rdEn;   // bus read request this cycle
    logic rdHit;  // bus read falls inside the memory range
    logic lkEn;   // pixel lookup request this cycle
  } strobe_t;

endpackage

// File: rtl/lutshr_ctrl.sv
module lutshr_ctrl
  import lutshr_pkg::*;
#(
  parameter int ENTRY_AW = 11,
  parameter int BUS_AW   = ENTRY_AW + 3,
  parameter int IDX_W    = 8,
  parameter int TILE_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [BUS_AW-1:2]   busWordAddr,
  input  logic                dispEnable,
  input  logic                vBlank,
  input  logic                pixValid,
  input  logic [IDX_W-1:0]    pixIndex,
  input  logic [ENTRY_AW-1:0] layerBase,
  input  logic [1:0]          layerMode,
  input  logic [TILE_W-1:0]   tileX,
  input  logic [TILE_W-1:0]   tileY,
  output strobe_t             stb,
  output logic [ENTRY_AW-1:0] busIdx,
  output logic [ENTRY_AW-1:0] lkIdx,
  output logic                wrErr
);

  localparam int SMALL_W = 4;
  localparam int TILE_AW = 2 * TILE_W;

  logic inRange;
  logic writeOpen;
  logic wrTry;
  logic [ENTRY_AW-1:0] lkOffset;

  assign inRange   = busWordAddr[BUS_AW-1];
  assign busIdx    = busWordAddr[BUS_AW-2:2];
  assign writeOpen = !dispEnable || vBlank;
  assign wrTry     = busSel && busWrite && inRange;

  always_comb begin
    stb.wrEn  = wrTry && writeOpen;
    stb.rdEn  = busSel && !busWrite;
    stb.rdHit = inRange;
    stb.lkEn  = pixValid;
  end

  always_comb begin
    unique case (lut_mode_e'(layerMode))
      MODE_PAL16: lkOffset = ENTRY_AW'(pixIndex[SMALL_W-1:0]);
      MODE_TILE:  lkOffset = ENTRY_AW'({tileY, tileX});
      default:    lkOffset = ENTRY_AW'(pixIndex);
    endcase
  end

  // Sum truncated to ENTRY_AW bits: wraps around the memory
  assign lkIdx = layerBase + lkOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr <= 1'b0;
    end else if (wrTry && !writeOpen) begin
      wrErr <= 1'b1;
    end
  end

  logic [TILE_AW-1:0] unusedTile;
  assign unusedTile = '0;

endmodule

// File: rtl/lutshr_dpath.sv
module lutshr_dpath
  import lutshr_pkg::*;
#(
  parameter int ENTRY_AW = 11,
  parameter int DATA_W   = 24,
  parameter int BUS_DW   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ENTRY_AW-1:0] busIdx,
  input  logic [ENTRY_AW-1:0] lkIdx,
  input  logic [BUS_DW-1:0]   wrData,
  output logic [BUS_DW-1:0]   busRdata,
  output logic                lutValid,
  output logic [DATA_W-1:0]   lutData
);

  localparam int ENTRIES = 1 << ENTRY_AW;

  logic [DATA_W-1:0] mem [ENTRIES];

  // Single write port; both read ports see the pre-write contents
  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      mem[busIdx] <= wrData[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.lkEn) begin
      lutData <= mem[lkIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lutValid <= 1'b0;
      busRdata <= '0;
    end else begin
      lutValid <= stb.lkEn;
      if (stb.rdEn) begin
        busRdata <= stb.rdHit ? BUS_DW'(mem[busIdx]) : '0;
      end
    end
  end

endmodule

// File: rtl/lut_share_ram.sv
module lut_share_ram
  import lutshr_pkg::*;
#(
  parameter int ENTRY_AW = 11,
  parameter int DATA_W   = 24,
  parameter int BUS_DW   = 32,
  parameter int IDX_W    = 8,
  parameter int TILE_W   = 3,
  localparam int BUS_AW  = ENTRY_AW + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [BUS_AW-1:0]   busAddr,
  input  logic [BUS_DW-1:0]   busWdata,
  output logic [BUS_DW-1:0]   busRdata,
  input  logic                dispEnable,
  input  logic                vBlank,
  input  logic                pixValid,
  input  logic [IDX_W-1:0]    pixIndex,
  input  logic [ENTRY_AW-1:0] layerBase,
  input  logic [1:0]          layerMode,
  input  logic [TILE_W-1:0]   tileX,
  input  logic [TILE_W-1:0]   tileY,
  output logic                lutValid,
  output logic [DATA_W-1:0]   lutData,
  output logic                wrErr
);

  strobe_t             stb;
  logic [ENTRY_AW-1:0] busIdx;
  logic [ENTRY_AW-1:0] lkIdx;

  logic unusedByteLane;
  assign unusedByteLane = ^busAddr[1:0];

  lutshr_ctrl #(
    .ENTRY_AW(ENTRY_AW), .BUS_AW(BUS_AW), .IDX_W(IDX_W), .TILE_W(TILE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busWordAddr(busAddr[BUS_AW-1:2]),
    .dispEnable(dispEnable), .vBlank(vBlank),
    .pixValid(pixValid), .pixIndex(pixIndex), .layerBase(layerBase),
    .layerMode(layerMode), .tileX(tileX), .tileY(tileY),
    .stb(stb), .busIdx(busIdx), .lkIdx(lkIdx), .wrErr(wrErr)
  );

  lutshr_dpath #(
    .ENTRY_AW(ENTRY_AW), .DATA_W(DATA_W), .BUS_DW(BUS_DW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busIdx(busIdx), .lkIdx(lkIdx), .wrData(busWdata),
    .busRdata(busRdata), .lutValid(lutValid), .lutData(lutData)
  );

endmodule

// File: rtl/lutshr_chk.sv
module lutshr_chk #(
  parameter int BUS_AW = 14,
  parameter int BUS_DW = 32,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [BUS_AW-1:0] busAddr,
  input logic [BUS_DW-1:0] busRdata,
  input logic              dispEnable,
  input logic              vBlank,
  input logic              pixValid,
  input logic              lutValid,
  input logic              wrErr
);

  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr[BUS_AW-1] && dispEnable && !vBlank) |=> wrErr); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |=> wrErr); // R4

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrErr) |-> $past(busSel && busWrite && busAddr[BUS_AW-1] && dispEnable && !vBlank)); // R3

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> lutValid); // R9

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !lutValid); // R9

  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !busAddr[BUS_AW-1]) |=> (busRdata == '0)); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_DW-1:DATA_W] == '0); // R1

endmodule

bind lut_share_ram lutshr_chk #(
  .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .dispEnable(dispEnable),
  .vBlank(vBlank), .pixValid(pixValid), .lutValid(lutValid), .wrErr(wrErr)
);

// File: tb/lut_share_ram_bench.sv
module lut_share_ram_bench;

  localparam int ENTRIES = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [13:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        dispEnable = 1'b0, vBlank = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixIndex = '0;
  logic [10:0] layerBase = '0;
  logic [1:0]  layerMode = '0;
  logic [2:0]  tileX = '0, tileY = '0;
  logic        lutValid;
  logic [23:0] lutData;
  logic        wrErr;

  int nCmp = 0;
  int nBad = 0;
  logic [23:0] model [ENTRIES];

  always #2.5 clk = ~clk;

  lut_share_ram u_lut_share_ram (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .dispEnable(dispEnable), .vBlank(vBlank), .pixValid(pixValid),
    .pixIndex(pixIndex), .layerBase(layerBase), .layerMode(layerMode),
    .tileX(tileX), .tileY(tileY), .lutValid(lutValid), .lutData(lutData),
    .wrErr(wrErr)
  );

  function automatic logic [23:0] pat(int i, int s);
    return 24'((i * 40503 + s * 7919 + 291) ^ (i << 9));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  task automatic busWr(int addr, logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 14'(addr); busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 14'(addr);
    @(negedge clk);
    busSel = 1'b0;
    chk(tag, busRdata, exp);
  endtask

  task automatic look(int base, int mode, int idx, int x, int y, string tag);
    int e;
    @(negedge clk);
    pixValid = 1'b1; layerBase = 11'(base); layerMode = 2'(mode);
    pixIndex = 8'(idx); tileX = 3'(x); tileY = 3'(y);
    if (mode == 0)      e = (base + (idx % 16)) % ENTRIES;
    else if (mode == 2) e = (base + 8 * y + x) % ENTRIES;
    else                e = (base + idx) % ENTRIES;
    @(negedge clk);
    pixValid = 1'b0;
    chk({tag, " valid"}, 32'(lutValid), 32'd1);
    chk(tag, 32'(lutData), 32'(model[e]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    int pal16Bases [4] = '{0, 16, 500, 2040};
    int pal256Bases [3] = '{0, 256, 1800};
    int tileBases [2] = '{64, 2000};

    repeat (3) @(negedge clk);
    chk("R10 busRdata", busRdata, 32'd0);
    chk("R10 lutValid", 32'(lutValid), 32'd0);
    chk("R10 wrErr", 32'(wrErr), 32'd0);
    rstN = 1'b1;

    // R1: fill with display off, upper data bits must be dropped
    for (int i = 0; i < ENTRIES; i++) begin
      model[i] = pat(i, 1);
      busWr(32'h2000 + 4 * i, {8'hEE, model[i]});
    end
    for (int i = 0; i < ENTRIES; i++) busRd(32'h2000 + 4 * i, 32'(model[i]), "R1 readback");
    chk("R1 no error", 32'(wrErr), 32'd0);

    // R9: valid timing
    @(negedge clk);
    pixValid = 1'b1; layerMode = 2'd1; layerBase = 11'd3; pixIndex = 8'd4;
    @(negedge clk);
    pixValid = 1'b0;
    chk("R9 valid one cycle later", 32'(lutValid), 32'd1);
    chk("R9 data", 32'(lutData), 32'(model[7]));
    @(negedge clk);
    chk("R9 valid drops", 32'(lutValid), 32'd0);

    // R5, R8: 16-colour mode, upper index bits ignored, wrap at 2040
    foreach (pal16Bases[b])
      for (int idx = 0; idx < 256; idx++) look(pal16Bases[b], 0, idx, 7, 7, "R5/R8 pal16");

    // R6, R8: 256-colour, both mode codes
    for (int m = 1; m <= 3; m += 2)
      foreach (pal256Bases[b])
        for (int idx = 0; idx < 256; idx++) look(pal256Bases[b], m, idx, 0, 0, "R6/R8 pal256");

    // R7, R8: tile mode, pixIndex held at a misleading value
    foreach (tileBases[b])
      for (int y = 0; y < 8; y++)
        for (int x = 0; x < 8; x++) look(tileBases[b], 2, 255 - x, x, y, "R7/R8 tile");

    // R2: outside range write ignored, read zero, alias entry unchanged
    busWr(32'h0100, 32'h00ABCDEF);
    busRd(32'h0100, 32'd0, "R2 outside read zero");
    busRd(32'h2100, 32'(model[64]), "R2 alias entry unchanged");
    chk("R2 no error", 32'(wrErr), 32'd0);

    // R3: display on but in vertical blanking
    dispEnable = 1'b1; vBlank = 1'b1;
    model[5] = pat(5, 2);
    busWr(32'h2000 + 4 * 5, 32'(model[5]));
    busRd(32'h2000 + 4 * 5, 32'(model[5]), "R3 blanking write taken");
    chk("R3 no error", 32'(wrErr), 32'd0);

    // R4: active scan, write dropped
    vBlank = 1'b0;
    busWr(32'h2000 + 4 * 6, 32'(pat(6, 3)));
    busRd(32'h2000 + 4 * 6, 32'(model[6]), "R4 dropped write");
    look(6, 1, 0, 0, 0, "R4 dropped write lookup");
    chk("R4 error set", 32'(wrErr), 32'd1);
    dispEnable = 1'b0;
    model[8] = pat(8, 4);
    busWr(32'h2000 + 4 * 8, 32'(model[8]));
    busRd(32'h2000 + 4 * 8, 32'(model[8]), "R3 display off write taken");
    chk("R4 error sticky", 32'(wrErr), 32'd1);

    // R11: same-cycle write and lookup on entry 7
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 14'(32'h2000 + 4 * 7);
    busWdata = 32'(pat(7, 5));
    pixValid = 1'b1; layerBase = 11'd7; layerMode = 2'd1; pixIndex = 8'd0;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; pixValid = 1'b0;
    chk("R11 old value on collision", 32'(lutData), 32'(model[7]));
    model[7] = pat(7, 5);
    look(7, 1, 0, 0, 0, "R11 new value after");

    // R10: reset again clears flag
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 wrErr after reset", 32'(wrErr), 32'd0);
    chk("R10 busRdata after reset", busRdata, 32'd0);
    rstN = 1'b1;

    summary();
    $finish;
  end

endmodule